// File: doc/BRIEF.md
# Exception Return Unstacking Sequencer

This block watches every write to the program counter together with a code for the kind of instruction that made it. When a qualifying write loads a value whose top 28 bits are all ones while a handler is active, the block treats it as an exception return. It then reads the eight-word context frame back through a simple memory read port and hands each word to the register file through a write strobe. At the end it reports the new stack pointer.

A small nesting stack holds the number and priority of each active handler. Handler entries are pushed by the entry logic. The stack gives the block the exiting handler's number and the priority of the context being resumed. It also drives a current-priority output and a three-bit trace status with a nine-bit interrupt number.

While the frame is being read, a pending exception whose priority is strictly more urgent than the resumed context stops the reads at once. The stack pointer is then written back with its value from before the pop, and a tail-chain pulse replaces the normal completion.

Top module: `exc_return_unstacker`

## Requirements
- R1: A write with `pcWrValid` high, `pcWrKind` 1 (multi-register pop including the program counter), 2 (single load into the program counter) or 3 (register branch-exchange), `pcWrData[31:4]` all ones and at least one active handler starts a pop. In the following cycle `busy` is high and `memReq` is asserted.
- R2: A program-counter write is ignored, with `busy`, `memReq` and `trcStat` staying low or zero, if any of these holds: its kind is 0 (plain branch), its upper 28 bits are not all ones, or no handler is active.
- R3: The frame is read at `curSp` (captured at the detecting write) plus these byte offsets in this order: 0x18 (return PC), 0x1C (status word), then 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14. A read is accepted in a cycle with `memReq` and `memReady` both high. In that cycle `regWrEn` is high, `regWrSel` equals offset/4 and `regWrData` equals `memData`. While `memReady` is low, the address holds.
- R4: In the cycle after the eighth accepted read, `spWrEn` and `retDone` pulse high for one cycle, and `spWrData` equals the captured stack pointer plus 0x20.
- R5: In the cycle after the detecting write, `trcStat` is 3'b010 and `trcNum` is the number of the exiting handler.
- R6: In the cycle after that, `trcStat` is 3'b011 and `trcNum` is the resumed handler's number if another handler remains active. Otherwise `trcStat` is 3'b000.
- R7: `trcStat` is 3'b000 in every other cycle.
- R8: During a pop, `pendValid` with `pendPri` numerically below the resumed context's priority (lower value is more urgent) drops `memReq` in that same cycle. In the next cycle `tailChain` and `spWrEn` pulse, `spWrData` equals the captured stack pointer, `retDone` stays low and `busy` is low.
- R9: `curPri` is 0xFF after reset and at thread level. An accepted handler entry sets it to the entry's priority. A detected return sets it to the resumed handler's priority, or to 0xFF if none remains.
- R10: Program-counter writes and handler entries that arrive while `busy` is high have no effect.
- R11: A pending exception whose priority equals or is less urgent than the resumed context does not stop the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pcWrValid | input | 1 | Program-counter write this cycle |
| pcWrData | input | 32 | Value written to the program counter |
| pcWrKind | input | 2 | 0 plain, 1 multi pop, 2 single load, 3 register branch-exchange |
| curSp | input | 32 | Current stack pointer from the register file |
| entryValid | input | 1 | A handler is being entered |
| entryNum | input | 9 | Number of the entered handler |
| entryPri | input | 8 | Priority of the entered handler |
| pendValid | input | 1 | A pending exception is requesting |
| pendPri | input | 8 | Priority of the pending exception |
| memReq | output | 1 | Frame read request |
| memAddr | output | 32 | Frame read address |
| memReady | input | 1 | Read accepted, data valid this cycle |
| memData | input | 32 | Read data |
| regWrEn | output | 1 | Frame word write to the register file |
| regWrSel | output | 3 | Frame word index (offset/4) |
| regWrData | output | 32 | Frame word data |
| spWrEn | output | 1 | Stack pointer write |
| spWrData | output | 32 | New stack pointer |
| retDone | output | 1 | Return completed |
| tailChain | output | 1 | Pop abandoned for a tail-chain |
| busy | output | 1 | Pop in progress |
| curPri | output | 8 | Current execution priority |
| trcStat | output | 3 | Trace status: 000 none, 010 exit, 011 resume |
| trcNum | output | 9 | Trace interrupt number |

## Verification
Returns are driven with each of the three qualifying instruction kinds. Each one is paired with near misses: a plain branch carrying the magic value, a qualifying kind whose value is off by one nibble, and a magic value with no handler active. Together these show that each of the three start conditions is really required. Pops are run with a stalled memory port, with stray entries and program-counter writes injected mid-pop, and both nested and down to thread level. These separate read ordering and holding from the trace sequence 010/011 versus 010/000, and from the priority restore. An equal-priority pending request followed by a more urgent one shows that the abort compares strictly and rewinds rather than advances the stack pointer.

// File: rtl/exr_pkg.sv
package exr_pkg;

  localparam int FRAME_WORDS = 8;
  localparam int STEP_W      = $clog2(FRAME_WORDS);
  localparam int FRAME_BYTES = FRAME_WORDS * 4;
  localparam int PC_WORD     = 6;

  typedef enum logic [1:0] {
    PCW_PLAIN     = 2'd0,
    PCW_POP_MULTI = 2'd1,
    PCW_LOAD_PC   = 2'd2,
    PCW_BX_REG    = 2'd3
  } pcWrKind_t;

  typedef enum logic [2:0] {
    TRC_NONE   = 3'b000,
    TRC_EXIT   = 3'b010,
    TRC_RESUME = 3'b011
  } trcStat_t;

  typedef struct packed {
    logic detect;
    logic readFire;
    logic lastFire;
    logic abort;
  } seqStrobe_t;

  // Read order: return PC, status word, then the general registers ascending.
  function automatic logic [STEP_W-1:0] frameWordOf(input logic [STEP_W-1:0] step);
    if (step < STEP_W'(2)) return step + STEP_W'(PC_WORD);
    else                   return step - STEP_W'(2);
  endfunction

endpackage

// File: rtl/exr_nest_stack.sv
module exr_nest_stack #(
  parameter int NUM_W = 9,
  parameter int PRI_W = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [NUM_W-1:0] pushNum,
  input  logic [PRI_W-1:0] pushPri,
  input  logic             pop,
  output logic             topValid,
  output logic [NUM_W-1:0] topNum,
  output logic             belowValid,
  output logic [NUM_W-1:0] belowNum,
  output logic [PRI_W-1:0] belowPri,
  output logic             full
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] depth;
  logic [NUM_W-1:0] numMem [DEPTH];
  logic [PRI_W-1:0] priMem [DEPTH];
  logic [IDX_W-1:0] topIdx, belowIdx;
  logic             doPush, doPop;

  assign full   = (depth == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && topValid;

  assign topValid   = (depth != '0);
  assign belowValid = (depth > CNT_W'(1));
  assign topIdx     = IDX_W'(depth - CNT_W'(1));
  assign belowIdx   = IDX_W'(depth - CNT_W'(2));
  assign topNum     = topValid   ? numMem[topIdx]   : '0;
  assign belowNum   = belowValid ? numMem[belowIdx] : '0;
  assign belowPri   = belowValid ? priMem[belowIdx] : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      depth <= '0;
    else if (doPush) depth <= depth + CNT_W'(1);
    else if (doPop)  depth <= depth - CNT_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        numMem[i] <= '0;
        priMem[i] <= '1;
      end else if (doPush && depth == CNT_W'(i)) begin
        numMem[i] <= pushNum;
        priMem[i] <= pushPri;
      end
    end
  end

  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));

  assert_no_push_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/exr_seq_ctrl.sv
module exr_seq_ctrl
  import exr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PRI_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcWrValid,
  input  logic [ADDR_W-1:4] pcWrHi,
  input  logic [1:0]        pcWrKind,
  input  logic              haveActive,
  input  logic              pendValid,
  input  logic [PRI_W-1:0]  pendPri,
  input  logic [PRI_W-1:0]  resumePri,
  input  logic              memReady,
  output seqStrobe_t        strobe,
  output logic [STEP_W-1:0] step,
  output logic              memReq,
  output logic              busy
);
  typedef enum logic {ST_IDLE, ST_POP} seqState_t;

  seqState_t state;
  logic      magicHit, kindOk, abortHit;

  assign busy     = (state == ST_POP);
  assign magicHit = &pcWrHi;
  assign kindOk   = (pcWrKind != PCW_PLAIN);
  assign abortHit = busy && pendValid && (pendPri < resumePri);

  assign strobe.detect   = !busy && pcWrValid && kindOk && magicHit && haveActive;
  assign strobe.abort    = abortHit;
  assign memReq          = busy && !abortHit;
  assign strobe.readFire = memReq && memReady;
  assign strobe.lastFire = strobe.readFire && (step == STEP_W'(FRAME_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strobe.detect) begin
          state <= ST_POP;
          step  <= '0;
        end
        ST_POP: begin
          if (abortHit || strobe.lastFire) state <= ST_IDLE;
          if (strobe.readFire)             step  <= step + STEP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_abort_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abortHit |=> !memReq && !busy);

  assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !memReady && !abortHit) |=> busy && $stable(step));

  assert_start_on_detect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.detect |=> memReq || abortHit);

endmodule

// File: rtl/exr_seq_dpath.sv
module exr_seq_dpath
  import exr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_W  = 9,
  parameter int PRI_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] curSp,
  input  logic [DATA_W-1:0] memData,
  input  logic [NUM_W-1:0]  topNum,
  input  logic              belowValid,
  input  logic [NUM_W-1:0]  belowNum,
  input  logic [PRI_W-1:0]  belowPri,
  input  logic              entryAccept,
  input  logic [PRI_W-1:0]  entryPri,
  output logic [ADDR_W-1:0] memAddr,
  output logic [STEP_W-1:0] regWrSel,
  output logic [DATA_W-1:0] regWrData,
  output logic              spWrEn,
  output logic [ADDR_W-1:0] spWrData,
  output logic              retDone,
  output logic              tailChain,
  output logic [PRI_W-1:0]  curPri,
  output logic [2:0]        trcStat,
  output logic [NUM_W-1:0]  trcNum
);
  logic [ADDR_W-1:0] spBase;
  logic [STEP_W-1:0] wordIdx;
  logic              resumePend;
  logic [NUM_W-1:0]  resumeNum;
  trcStat_t          trcReg;

  assign wordIdx   = frameWordOf(step);
  assign memAddr   = spBase + ADDR_W'({wordIdx, 2'b00});
  assign regWrSel  = wordIdx;
  assign regWrData = memData;
  assign trcStat   = trcReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spBase    <= '0;
      spWrEn    <= 1'b0;
      spWrData  <= '0;
      retDone   <= 1'b0;
      tailChain <= 1'b0;
    end else begin
      if (strobe.detect) spBase <= curSp;
      spWrEn    <= strobe.lastFire || strobe.abort;
      retDone   <= strobe.lastFire;
      tailChain <= strobe.abort;
      if (strobe.abort)         spWrData <= spBase;
      else if (strobe.lastFire) spWrData <= spBase + ADDR_W'(FRAME_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trcReg     <= TRC_NONE;
      trcNum     <= '0;
      resumePend <= 1'b0;
      resumeNum  <= '0;
    end else if (strobe.detect) begin
      trcReg     <= TRC_EXIT;
      trcNum     <= topNum;
      resumePend <= belowValid;
      resumeNum  <= belowNum;
    end else if (trcReg == TRC_EXIT && resumePend) begin
      trcReg <= TRC_RESUME;
      trcNum <= resumeNum;
    end else begin
      trcReg <= TRC_NONE;
      trcNum <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              curPri <= '1;
    else if (strobe.detect)  curPri <= belowValid ? belowPri : '1;
    else if (entryAccept)    curPri <= entryPri;
  end

  assert_resume_follows_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trcReg == TRC_RESUME |-> $past(trcReg) == TRC_EXIT);

  assert_exit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trcReg == TRC_EXIT |=> trcReg != TRC_EXIT);

  assert_done_xor_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(retDone && tailChain));

  assert_sp_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retDone |-> spWrEn && spWrData == spBase + ADDR_W'(FRAME_BYTES));

  assert_sp_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tailChain |-> spWrEn && spWrData == spBase);

endmodule

// File: rtl/exc_return_unstacker.sv
module exc_return_unstacker
  import exr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_W      = 9,
  parameter int PRI_W      = 8,
  parameter int NEST_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcWrValid,
  input  logic [ADDR_W-1:0] pcWrData,
  input  logic [1:0]        pcWrKind,
  input  logic [ADDR_W-1:0] curSp,
  input  logic              entryValid,
  input  logic [NUM_W-1:0]  entryNum,
  input  logic [PRI_W-1:0]  entryPri,
  input  logic              pendValid,
  input  logic [PRI_W-1:0]  pendPri,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memData,
  output logic              regWrEn,
  output logic [2:0]        regWrSel,
  output logic [DATA_W-1:0] regWrData,
  output logic              spWrEn,
  output logic [ADDR_W-1:0] spWrData,
  output logic              retDone,
  output logic              tailChain,
  output logic              busy,
  output logic [PRI_W-1:0]  curPri,
  output logic [2:0]        trcStat,
  output logic [NUM_W-1:0]  trcNum
);
  seqStrobe_t        strobe;
  logic [STEP_W-1:0] step;
  logic              topValid, belowValid, stackFull, entryAccept;
  logic [NUM_W-1:0]  topNum, belowNum;
  logic [PRI_W-1:0]  belowPri;
  logic              unusedPcLow;

  assign unusedPcLow = ^pcWrData[3:0];
  assign entryAccept = entryValid && !busy && !strobe.detect && !stackFull;
  assign regWrEn     = strobe.readFire;

  exr_seq_ctrl #(.ADDR_W(ADDR_W), .PRI_W(PRI_W)) u_ctrl (
    .clk, .rst_n, .pcWrValid,
    .pcWrHi     (pcWrData[ADDR_W-1:4]),
    .pcWrKind,
    .haveActive (topValid),
    .pendValid, .pendPri,
    .resumePri  (curPri),
    .memReady,
    .strobe, .step, .memReq, .busy
  );

  exr_nest_stack #(.NUM_W(NUM_W), .PRI_W(PRI_W), .DEPTH(NEST_DEPTH)) u_nest (
    .clk, .rst_n,
    .push    (entryAccept),
    .pushNum (entryNum),
    .pushPri (entryPri),
    .pop     (strobe.detect),
    .topValid, .topNum, .belowValid, .belowNum, .belowPri,
    .full    (stackFull)
  );

  exr_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_W(NUM_W), .PRI_W(PRI_W)) u_dpath (
    .clk, .rst_n, .strobe, .step, .curSp, .memData,
    .topNum, .belowValid, .belowNum, .belowPri,
    .entryAccept, .entryPri,
    .memAddr, .regWrSel, .regWrData, .spWrEn, .spWrData,
    .retDone, .tailChain, .curPri, .trcStat, .trcNum
  );

  assert_busy_ignores_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !strobe.detect) |=> curPri == $past(curPri));

endmodule

// File: tb/exc_return_unstacker_bench.sv
`timescale 1ns/1ps
module exc_return_unstacker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pcWrValid = 1'b0;
  logic [31:0] pcWrData = '0;
  logic [1:0]  pcWrKind = '0;
  logic [31:0] curSp = '0;
  logic        entryValid = 1'b0;
  logic [8:0]  entryNum = '0;
  logic [7:0]  entryPri = '0;
  logic        pendValid = 1'b0;
  logic [7:0]  pendPri = '0;
  logic        memReady = 1'b0;
  logic [31:0] memData;
  logic        memReq, regWrEn, spWrEn, retDone, tailChain, busy;
  logic [31:0] memAddr, regWrData, spWrData;
  logic [2:0]  regWrSel, trcStat;
  logic [7:0]  curPri;
  logic [8:0]  trcNum;

  localparam logic [31:0] DKEY = 32'h5A5A_0000;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;
  assign memData = memAddr ^ DKEY;

  exc_return_unstacker u_exc_return_unstacker (
    .clk, .rst_n, .pcWrValid, .pcWrData, .pcWrKind, .curSp,
    .entryValid, .entryNum, .entryPri, .pendValid, .pendPri,
    .memReq, .memAddr, .memReady, .memData,
    .regWrEn, .regWrSel, .regWrData, .spWrEn, .spWrData,
    .retDone, .tailChain, .busy, .curPri, .trcStat, .trcNum
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pushEntry(input logic [8:0] num, input logic [7:0] pri);
    entryValid = 1'b1; entryNum = num; entryPri = pri;
    @(negedge clk);
    entryValid = 1'b0;
    chk(curPri == pri, "R9", "curPri after entry", curPri, pri);
  endtask

  task automatic tryIgnored(input logic [1:0] kind, input logic [31:0] val);
    pcWrValid = 1'b1; pcWrKind = kind; pcWrData = val;
    @(negedge clk);
    pcWrValid = 1'b0;
    chk(!busy && !memReq, "R2", "busy/memReq after ignored write", {busy, memReq}, 0);
    chk(trcStat == 3'b000, "R2", "trcStat after ignored write", trcStat, 0);
    @(negedge clk);
    chk(trcStat == 3'b000 && !busy, "R2", "still idle", {trcStat, busy}, 0);
  endtask

  task automatic traceAt(input int cyc, input logic [8:0] exitNum, input bit nested,
                         input logic [8:0] retNum);
    if (cyc == 0) begin
      chk(trcStat == 3'b010, "R5", "exit status", trcStat, 3'b010);
      chk(trcNum == exitNum, "R5", "exit number", trcNum, exitNum);
    end else if (cyc == 1) begin
      chk(trcStat == (nested ? 3'b011 : 3'b000), "R6", "resume status", trcStat,
          nested ? 3'b011 : 3'b000);
      if (nested) chk(trcNum == retNum, "R6", "resume number", trcNum, retNum);
    end else begin
      chk(trcStat == 3'b000, "R7", "quiet status", trcStat, 0);
    end
  endtask

  task automatic runReturn(input logic [1:0] kind, input logic [31:0] pcVal,
                           input logic [31:0] sp, input logic [8:0] exitNum,
                           input bit nested, input logic [8:0] retNum,
                           input logic [7:0] retPri, input int stallStep,
                           input int abortStep, input bit busyPoke);
    int cyc = 0;
    curSp = sp; pcWrValid = 1'b1; pcWrKind = kind; pcWrData = pcVal; memReady = 1'b0;
    @(negedge clk);
    pcWrValid = 1'b0;
    chk(busy == 1'b1, "R1", "busy after qualifying write", busy, 1);
    chk(curPri == retPri, "R9", "curPri after return", curPri, retPri);
    for (int s = 0; s < 8; s++) begin
      int w;
      logic [31:0] a;
      w = (s < 2) ? s + 6 : s - 2;
      a = sp + 32'(w * 4);
      if (abortStep >= 0 && s == abortStep + 1) begin
        pendValid = 1'b1; pendPri = retPri - 8'd1; memReady = 1'b1;
        #1;
        chk(!memReq && !regWrEn, "R8", "read suppressed on abort", {memReq, regWrEn}, 0);
        traceAt(cyc, exitNum, nested, retNum);
        @(negedge clk);
        pendValid = 1'b0; memReady = 1'b0;
        chk(tailChain && spWrEn && !retDone, "R8", "tailChain/spWrEn/retDone",
            {tailChain, spWrEn, retDone}, 3'b110);
        chk(spWrData == sp, "R8", "rewound stack pointer", spWrData, sp);
        chk(!busy, "R8", "idle after abort", busy, 0);
        @(negedge clk);
        chk(!tailChain && !spWrEn && !memReq, "R8", "pulse ends",
            {tailChain, spWrEn, memReq}, 0);
        chk(curPri == retPri, "R9", "curPri after abort", curPri, retPri);
        return;
      end
      if (s == stallStep) begin
        memReady = 1'b0;
        #1;
        chk(memReq && memAddr == a && !regWrEn, "R3", "stalled read holds",
            memAddr, a);
        traceAt(cyc, exitNum, nested, retNum);
        @(negedge clk); cyc++;
      end
      memReady = 1'b1;
      if (s == abortStep) begin pendValid = 1'b1; pendPri = retPri; end
      if (busyPoke && s == 4) begin
        entryValid = 1'b1; entryNum = 9'h1FF; entryPri = 8'h00;
        pcWrValid = 1'b1; pcWrKind = 2'd1; pcWrData = 32'hFFFF_FFF1;
      end
      #1;
      chk(memReq && memAddr == a, "R3", "read address", memAddr, a);
      chk(regWrEn && regWrSel == 3'(w), "R3", "register select", regWrSel, w);
      chk(regWrData == (a ^ DKEY), "R3", "register data", regWrData, a ^ DKEY);
      traceAt(cyc, exitNum, nested, retNum);
      @(negedge clk); cyc++;
      pendValid = 1'b0; entryValid = 1'b0; pcWrValid = 1'b0;
      if (s == abortStep) chk(busy || s == 7, "R11", "equal priority does not abort", busy, 1);
    end
    memReady = 1'b0;
    chk(spWrEn && retDone && !tailChain, "R4", "completion pulse",
        {spWrEn, retDone, tailChain}, 3'b110);
    chk(spWrData == sp + 32'h20, "R4", "advanced stack pointer", spWrData, sp + 32'h20);
    chk(curPri == retPri, "R10", "curPri unchanged by mid-pop entry", curPri, retPri);
    @(negedge clk);
    chk(!spWrEn && !retDone && !busy, "R4", "single pulse", {spWrEn, retDone, busy}, 0);
    chk(trcStat == 3'b000, "R10", "no return started mid-pop", trcStat, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !memReq && !spWrEn, "R7", "reset outputs", {busy, memReq, spWrEn}, 0);
    chk(trcStat == 3'b000, "R7", "reset status", trcStat, 0);
    chk(curPri == 8'hFF, "R9", "reset priority", curPri, 8'hFF);

    tryIgnored(2'd1, 32'hFFFF_FFF9);          // R2: no active handler
    pushEntry(9'h034, 8'h60);
    pushEntry(9'h009, 8'h20);
    tryIgnored(2'd0, 32'hFFFF_FFF9);          // R2: plain branch kind
    tryIgnored(2'd2, 32'hFFFF_FFE9);          // R2: value not magic
    chk(curPri == 8'h20, "R2", "priority unchanged by ignored writes", curPri, 8'h20);

    // R1 kind 3, nested return with stall and mid-pop pokes (R10)
    runReturn(2'd3, 32'hFFFF_FFF9, 32'h2000_1000, 9'h009, 1'b1, 9'h034, 8'h60, 3, -1, 1'b1);
    // R1 kind 2, return to thread level
    runReturn(2'd2, 32'hFFFF_FFFD, 32'h2000_1020, 9'h034, 1'b0, 9'h000, 8'hFF, -1, -1, 1'b0);
    chk(curPri == 8'hFF, "R9", "thread level priority", curPri, 8'hFF);

    // R8/R11 abandon and tail-chain
    pushEntry(9'h005, 8'h40);
    pushEntry(9'h1A1, 8'h10);
    runReturn(2'd2, 32'hFFFF_FFF1, 32'h2000_2000, 9'h1A1, 1'b1, 9'h005, 8'h40, -1, 3, 1'b0);
    pushEntry(9'h00C, 8'h30);
    // R1 kind 1 from the chained handler, then back to thread
    runReturn(2'd1, 32'hFFFF_FFF9, 32'h2000_2000, 9'h00C, 1'b1, 9'h005, 8'h40, 7, -1, 1'b0);
    runReturn(2'd1, 32'hFFFF_FFF9, 32'h2000_2020, 9'h005, 1'b0, 9'h000, 8'hFF, 0, -1, 1'b0);
    tryIgnored(2'd3, 32'hFFFF_FFF9);          // R2: stack empty again

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule